// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block is a one-direction holding queue inside a bus bridge. It accepts three kinds of transaction: posted writes, delayed requests and delayed completions. Each is kept as a small record holding its class, a committed bit and an 8-bit tag. Unlike a FIFO, the queue chooses each cycle which resident entry goes out next. A younger entry may go ahead of an older one when the ordering rules allow it. Entries that the rules mark as disposable can be removed on request.

Entries are kept in arrival order. An entry may leave when no older posted write is still queued and its class is not stalled by the downstream side through `cls_stall`. Among the entries that may leave, the oldest wins. A separate drop port names an entry by tag. The drop succeeds only for an uncommitted delayed request or for the oldest completion in the queue. Any other drop request changes nothing and raises a sticky error flag.

Top module: `txn_order_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid` is 0, `in_ready` is 1 and `drop_err` is 0.
- R2: Posted writes (class code 2'b00) leave in the order they arrived among themselves. An entry arrives on a cycle with `in_valid` and `in_ready` both high.
- R3: A delayed request (code 2'b01) or a completion (code 2'b10) is never presented while an older posted write is still queued.
- R4: A delayed request or completion may leave ahead of older delayed requests and completions, for example when their class is stalled.
- R5: A posted write may leave ahead of older delayed requests and completions.
- R6: `cls_stall` bit 0 holds back posted writes, bit 1 holds back requests and bit 2 holds back completions. Among the entries that are not held back and that R2/R3 allow to leave, the oldest is presented on `out_id`/`out_cls`/`out_cmt`. The entry is removed on a cycle where `out_valid` and `out_ready` are both high.
- R7: A drop of an uncommitted delayed request (`in_cmt` was 0) removes it on that cycle, and `drop_err` stays unchanged.
- R8: A completion can be dropped only while it is the oldest completion in the queue. A drop naming a younger completion leaves the queue unchanged and sets `drop_err`.
- R9: A drop naming a posted write, a committed request or an absent tag leaves the queue unchanged and sets `drop_err`. Once set, `drop_err` stays at 1 until reset.
- R10: While `drop_valid` is high, `out_valid` is 0. `in_ready` is 0 when the queue holds DEPTH entries, and a push attempted in that state is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming entry is offered |
| in_ready | output | 1 | Queue has a free slot |
| in_cls | input | 2 | Class code of the incoming entry |
| in_cmt | input | 1 | Committed bit of the incoming entry |
| in_id | input | 8 | Tag of the incoming entry |
| out_valid | output | 1 | An entry is presented |
| out_ready | input | 1 | Downstream takes the presented entry |
| out_cls | output | 2 | Class code of the presented entry |
| out_cmt | output | 1 | Committed bit of the presented entry |
| out_id | output | 8 | Tag of the presented entry |
| cls_stall | input | 3 | Per-class hold-back mask |
| drop_valid | input | 1 | Drop request strobe |
| drop_id | input | 8 | Tag of the entry to drop |
| drop_err | output | 1 | Sticky flag for a refused drop |

## Verification
The assertions assume that `in_cls` never carries code 2'b11. They also assume that tags of resident entries are distinct, so a drop names at most one entry. The stimulus uses only the three defined codes. It draws every tag from a fresh value, and it never pushes a tag that is already queued. The bench keeps its own arrival-ordered copy of the queue. On each departure it confirms that no older posted write was left behind.

// File: rtl/tq_pkg.sv
package tq_pkg;

    localparam int TQ_ID_W = 8;

    typedef enum logic [1:0] {
        CLS_PST = 2'b00,
        CLS_REQ = 2'b01,
        CLS_CPL = 2'b10,
        CLS_BAD = 2'b11
    } tq_cls_e;

    typedef struct packed {
        tq_cls_e              cls;
        logic                 cmt;
        logic [TQ_ID_W-1:0]   id;
    } tq_ent_t;

    // An older posted write is the only thing that blocks a younger entry.
    function automatic logic blocks_younger(tq_cls_e older);
        return older == CLS_PST;
    endfunction

    function automatic logic held_back(tq_cls_e c, logic [2:0] stall);
        case (c)
            CLS_PST: return stall[0];
            CLS_REQ: return stall[1];
            CLS_CPL: return stall[2];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tq_elig.sv
module tq_elig
    import tq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  tq_ent_t          ents [DEPTH],
    input  logic [DEPTH-1:0] occ,
    input  logic [2:0]       stall,
    output logic [DEPTH-1:0] can_out,
    output logic [DEPTH-1:0] can_drop
);

    logic [DEPTH:0] pst_before;
    logic [DEPTH:0] cpl_before;

    assign pst_before[0] = 1'b0;
    assign cpl_before[0] = 1'b0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign pst_before[i+1] = pst_before[i] | (occ[i] & blocks_younger(ents[i].cls));
        assign cpl_before[i+1] = cpl_before[i] | (occ[i] & (ents[i].cls == CLS_CPL));

        assign can_out[i] = occ[i] & ~pst_before[i] & ~held_back(ents[i].cls, stall);

        assign can_drop[i] = occ[i] &
            (((ents[i].cls == CLS_REQ) & ~ents[i].cmt) |
             ((ents[i].cls == CLS_CPL) & ~cpl_before[i]));
    end

endmodule

// File: rtl/tq_pick.sv
module tq_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/txn_order_queue.sv
module txn_order_queue
    import tq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_cls,
    input  logic                in_cmt,
    input  logic [TQ_ID_W-1:0]  in_id,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [1:0]          out_cls,
    output logic                out_cmt,
    output logic [TQ_ID_W-1:0]  out_id,
    input  logic [2:0]          cls_stall,
    input  logic                drop_valid,
    input  logic [TQ_ID_W-1:0]  drop_id,
    output logic                drop_err
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tq_ent_t          ents   [DEPTH];
    tq_ent_t          ents_n [DEPTH];
    tq_ent_t          shl    [DEPTH];
    logic [CW-1:0]    count, count_n, wr_pos;
    logic [DEPTH-1:0] occ, can_out, can_drop, id_hit;
    logic             out_any, id_any, drop_go, drop_bad, rm_en, push;
    logic [IW-1:0]    out_idx, id_idx, rm_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            occ[i]    = i < int'(count);
            id_hit[i] = occ[i] && (ents[i].id == drop_id);
        end
    end

    tq_elig #(.DEPTH(DEPTH)) elig_i (
        .ents     (ents),
        .occ      (occ),
        .stall    (cls_stall),
        .can_out  (can_out),
        .can_drop (can_drop)
    );

    tq_pick #(.N(DEPTH)) out_pick_i (.req(can_out), .hit(out_any), .idx(out_idx));
    tq_pick #(.N(DEPTH)) id_pick_i  (.req(id_hit),  .hit(id_any),  .idx(id_idx));

    assign drop_go   = drop_valid && id_any && can_drop[id_idx];
    assign drop_bad  = drop_valid && !drop_go;
    assign out_valid = out_any && !drop_valid;
    assign out_cls   = ents[out_idx].cls;
    assign out_cmt   = ents[out_idx].cmt;
    assign out_id    = ents[out_idx].id;
    assign in_ready  = int'(count) < DEPTH;
    assign push      = in_valid && in_ready;
    assign rm_en     = drop_go || (out_valid && out_ready);
    assign rm_idx    = drop_go ? id_idx : out_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_shift
        if (i < DEPTH - 1) begin : g_mid
            assign shl[i] = ents[i+1];
        end else begin : g_top
            assign shl[i] = ents[i];
        end
    end

    always_comb begin
        wr_pos  = count - CW'(rm_en);
        count_n = wr_pos + CW'(push);
        for (int i = 0; i < DEPTH; i++) begin
            ents_n[i] = (rm_en && i >= int'(rm_idx)) ? shl[i] : ents[i];
            if (push && i == int'(wr_pos)) begin
                ents_n[i] = '{cls: tq_cls_e'(in_cls), cmt: in_cmt, id: in_id};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            drop_err <= 1'b0;
        end else begin
            count <= count_n;
            if (drop_bad) drop_err <= 1'b1;
        end
        ents <= ents_n;
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !drop_err));
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);
    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !rm_en) |=> $stable(count));
    // R10
    drop_mutes_out_chk: assert property (@(posedge clk) disable iff (rst)
        drop_valid |-> !out_valid);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        drop_err |=> drop_err);
    // R6
    pst_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cls == 2'b00) |-> !cls_stall[0]);
    // R6
    req_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cls == 2'b01) |-> !cls_stall[1]);
    // R6
    cpl_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cls == 2'b10) |-> !cls_stall[2]);

endmodule

// File: tb/txn_order_queue_tb.sv
`timescale 1ns/1ps
module txn_order_queue_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready, in_cmt;
    logic [1:0] in_cls;
    logic [7:0] in_id;
    logic       out_valid, out_ready, out_cmt;
    logic [1:0] out_cls;
    logic [7:0] out_id;
    logic [2:0] cls_stall;
    logic       drop_valid, drop_err;
    logic [7:0] drop_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    txn_order_queue dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
        .in_cmt(in_cmt), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls),
        .out_cmt(out_cmt), .out_id(out_id),
        .cls_stall(cls_stall), .drop_valid(drop_valid), .drop_id(drop_id),
        .drop_err(drop_err)
    );

    localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_PEEK = 2'd2, OP_DROP = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] cls;
        logic       cmt;
        logic [7:0] id;
        logic [2:0] stall;
        logic       ev;
        logic [7:0] eid;
        logic       eerr;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{OP_PUSH, 2'd0, 1'b0, 8'd10, 3'b000, 1'b0, 8'd0,  1'b0, 4'd10}, // R10
        '{OP_PUSH, 2'd1, 1'b1, 8'd20, 3'b000, 1'b0, 8'd0,  1'b0, 4'd10},
        '{OP_PUSH, 2'd2, 1'b0, 8'd30, 3'b000, 1'b0, 8'd0,  1'b0, 4'd10},
        '{OP_PUSH, 2'd0, 1'b0, 8'd11, 3'b000, 1'b0, 8'd0,  1'b0, 4'd10},
        '{OP_PUSH, 2'd1, 1'b0, 8'd21, 3'b000, 1'b0, 8'd0,  1'b0, 4'd10},
        '{OP_PUSH, 2'd2, 1'b0, 8'd31, 3'b000, 1'b0, 8'd0,  1'b0, 4'd10},
        '{OP_POP,  2'd0, 1'b0, 8'd0,  3'b000, 1'b1, 8'd10, 1'b0, 4'd6},  // R6 oldest wins
        '{OP_POP,  2'd0, 1'b0, 8'd0,  3'b010, 1'b1, 8'd30, 1'b0, 4'd4},  // R4 cpl passes req
        '{OP_POP,  2'd0, 1'b0, 8'd0,  3'b100, 1'b1, 8'd20, 1'b0, 4'd6},
        '{OP_PEEK, 2'd0, 1'b0, 8'd0,  3'b001, 1'b0, 8'd0,  1'b0, 4'd3},  // R3 blocked by posted
        '{OP_DROP, 2'd0, 1'b0, 8'd21, 3'b000, 1'b0, 8'd0,  1'b0, 4'd7},  // R7
        '{OP_DROP, 2'd0, 1'b0, 8'd11, 3'b000, 1'b0, 8'd0,  1'b1, 4'd9},  // R9 posted kept
        '{OP_POP,  2'd0, 1'b0, 8'd0,  3'b000, 1'b1, 8'd11, 1'b1, 4'd2},  // R2
        '{OP_POP,  2'd0, 1'b0, 8'd0,  3'b000, 1'b1, 8'd31, 1'b1, 4'd3},
        '{OP_PEEK, 2'd0, 1'b0, 8'd0,  3'b000, 1'b0, 8'd0,  1'b1, 4'd10}
    };

    // Reference model of arrival order
    logic [7:0] m_id  [16];
    logic [1:0] m_cls [16];
    int         m_n = 0;

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_remove(input logic [7:0] id, input bit order_chk);
        int k = -1;
        for (int j = 0; j < m_n; j++) if (k < 0 && m_id[j] == id) k = j;
        if (k < 0) begin
            check(1'b0, 2, "departed tag unknown to model", id, 0);
            return;
        end
        if (order_chk) begin
            int older_pst = 0;
            for (int j = 0; j < k; j++) if (m_cls[j] == 2'd0) older_pst++;
            // R2 / R3: nothing leaves ahead of an older posted write
            check(older_pst == 0, (m_cls[k] == 2'd0) ? 2 : 3,
                  "departure passed older posted write", older_pst, 0);
        end
        for (int j = k; j < m_n - 1; j++) begin
            m_id[j]  = m_id[j+1];
            m_cls[j] = m_cls[j+1];
        end
        m_n--;
    endtask

    task automatic step(input logic [1:0] op, input logic [1:0] cls, input logic cmt,
                        input logic [7:0] id, input logic [2:0] stall, input logic ev,
                        input logic [7:0] eid, input logic eerr, input int req);
        bit accepted;
        @(negedge clk);
        cls_stall  = stall;
        in_valid   = (op == OP_PUSH);
        in_cls     = cls;
        in_cmt     = cmt;
        in_id      = id;
        out_ready  = (op == OP_POP);
        drop_valid = (op == OP_DROP);
        drop_id    = id;
        #1;
        accepted = in_ready;
        if (op != OP_PUSH) begin
            check(out_valid == ev, req, "out_valid", out_valid, ev);
            if (ev && out_valid)
                check(out_id == eid, req, "out_id", out_id, eid);
            if (op == OP_POP && out_valid) model_remove(out_id, 1'b1);
        end
        @(posedge clk);
        #1;
        in_valid = 0; out_ready = 0; drop_valid = 0;
        if (op == OP_PUSH && accepted) begin
            m_id[m_n] = id; m_cls[m_n] = cls; m_n++;
        end
        if (op == OP_DROP && !eerr) model_remove(id, 1'b0);
        check(drop_err == eerr, req, "drop_err", drop_err, eerr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        m_n = 0;
    endtask

    initial begin
        rst = 1; in_valid = 0; in_cls = 0; in_cmt = 0; in_id = 0;
        out_ready = 0; cls_stall = 0; drop_valid = 0; drop_id = 0;
        do_reset();

        // R1 reset state
        @(negedge clk); #1;
        check(out_valid == 0, 1, "out_valid after reset", out_valid, 0);
        check(in_ready == 1, 1, "in_ready after reset", in_ready, 1);
        check(drop_err == 0, 1, "drop_err after reset", drop_err, 0);

        for (int v = 0; v < NV; v++)
            step(VECS[v].op, VECS[v].cls, VECS[v].cmt, VECS[v].id, VECS[v].stall,
                 VECS[v].ev, VECS[v].eid, VECS[v].eerr, int'(VECS[v].req));

        // R8 younger completion refused, R9 committed request refused
        do_reset();
        step(OP_PUSH, 2'd2, 0, 8'd40, 3'b000, 0, 0, 0, 10);
        step(OP_PUSH, 2'd2, 0, 8'd41, 3'b000, 0, 0, 0, 10);
        step(OP_PUSH, 2'd1, 1, 8'd42, 3'b000, 0, 0, 0, 10);
        step(OP_DROP, 2'd0, 0, 8'd41, 3'b000, 0, 0, 1, 8);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b000, 1, 8'd40, 1, 8);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b000, 1, 8'd41, 1, 8);
        step(OP_DROP, 2'd0, 0, 8'd42, 3'b000, 0, 0, 1, 9);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b000, 1, 8'd42, 1, 9);

        // R8 oldest completion may be dropped
        do_reset();
        step(OP_PUSH, 2'd2, 0, 8'd50, 3'b000, 0, 0, 0, 10);
        step(OP_PUSH, 2'd2, 0, 8'd51, 3'b000, 0, 0, 0, 10);
        step(OP_DROP, 2'd0, 0, 8'd50, 3'b000, 0, 0, 0, 8);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b000, 1, 8'd51, 0, 8);
        step(OP_PEEK, 2'd0, 0, 8'd0,  3'b000, 0, 0, 0, 8);
        // R9 absent tag refused
        step(OP_DROP, 2'd0, 0, 8'd77, 3'b000, 0, 0, 1, 9);

        // R10 full queue, R2 posted order
        do_reset();
        for (int k = 0; k < 8; k++)
            step(OP_PUSH, 2'd0, 0, 8'(60 + k), 3'b000, 0, 0, 0, 10);
        @(negedge clk); #1;
        check(in_ready == 0, 10, "in_ready when full", in_ready, 0);
        step(OP_PUSH, 2'd0, 0, 8'd99, 3'b000, 0, 0, 0, 10);
        for (int k = 0; k < 8; k++)
            step(OP_POP, 2'd0, 0, 8'd0, 3'b000, 1, 8'(60 + k), 0, 2);
        step(OP_PEEK, 2'd0, 0, 8'd0, 3'b000, 0, 0, 0, 10);

        // R5 posted passes a stalled request, R2 order kept
        do_reset();
        step(OP_PUSH, 2'd1, 1, 8'd70, 3'b000, 0, 0, 0, 10);
        step(OP_PUSH, 2'd0, 0, 8'd71, 3'b000, 0, 0, 0, 10);
        step(OP_PUSH, 2'd0, 0, 8'd72, 3'b000, 0, 0, 0, 10);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b010, 1, 8'd71, 0, 5);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b010, 1, 8'd72, 0, 2);
        step(OP_POP,  2'd0, 0, 8'd0,  3'b000, 1, 8'd70, 0, 5);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule